// File: doc/BRIEF.md
# I2C Interrupt Flag Generator

This block sits next to an I2C bus controller and decides when a single interrupt request to the CPU is raised. The bus engine feeds it one-cycle event strobes: start and stop conditions, SCL rising and falling edges with the index of the clock within the byte, arbitration loss, own-address match, general call and the received acknowledge bit. Static control bits select master or slave operation and the timing and filtering rules. The result is a sticky flag. It stays set until the CPU writes 0 to it.

In master mode the flag is raised for these events: the first frame is ready after this controller's own start appears on the bus, a byte boundary, and the first frame received after arbitration was lost. In slave mode it is raised on an address match or a general call. It is then raised again at each byte boundary while the address-match window stays open. A repeated start or a stop closes that window. In both modes it is raised for a negative acknowledge when acknowledge checking is enabled, for arbitration loss when that interrupt is enabled, and for a stop condition unless stop interrupts are masked.

All events are taken on the rising clock edge. The flag, and the irq output that equals it, change one cycle after the event is presented.

Top module: `i2c_irq_flag_gen`

## Requirements
- R1: After a synchronous reset, irq is 0. A reset asserted while the flag is set clears it on the next edge.
- R2: With mode_master=1, start_det=1 and start_req=1 in one cycle, irq is 1 on the next cycle.
- R3: With wait_en=1, scl_fall with bit_idx=8 sets the flag. In master mode, scl_rise with bit_idx=9 does not set it unless R5 applies.
- R4: With wait_en=0, scl_rise with bit_idx=9 sets the flag. scl_fall with bit_idx=8 does not, and scl_rise with bit_idx=8 does not.
- R5: In master mode, the flag is set by the first scl_rise with bit_idx=9 that follows a start_det, if arb_lost was pulsed after that start. This holds even with wait_en=1. Later frames do not set it this way.
- R6: arb_lost with al_irq_en=1 sets the flag. arb_lost with al_irq_en=0 does not.
- R7: In either mode, ack_rx with ack_val=1 and ack_chk_en=1 sets the flag. ack_val=0 does not set it, and ack_chk_en=0 does not set it.
- R8: In slave mode, addr_match sets the flag and opens the match window. While the window is open, each byte boundary sets the flag, using the boundary chosen by R3 and R4.
- R9: In slave mode, gcall_det with rw_bit=0 sets the flag and opens the window. gcall_det with rw_bit=1 does neither.
- R10: start_det, stop_det or err_stop_det closes the window. While it is closed, slave byte boundaries do not set the flag. After reset the window is closed.
- R11: stop_det or err_stop_det with stop_irq_mask=0 sets the flag in either mode. With stop_irq_mask=1 they do not.
- R12: The flag holds its value. It is cleared only when clr_we=1 and clr_wdata=0. A write of 1 leaves it unchanged. A set event in the same cycle as a clear leaves it at 1.
- R13: start_det without start_req does not set the flag in master mode. start_det in slave mode does not set it at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_master | input | 1 | 1 = master operation, 0 = slave |
| wait_en | input | 1 | 1 = byte boundary at 8th SCL fall, 0 = at 9th SCL rise |
| ack_chk_en | input | 1 | Enable interrupt on received negative acknowledge |
| al_irq_en | input | 1 | Enable interrupt on arbitration loss |
| stop_irq_mask | input | 1 | 1 = stop conditions do not raise the flag |
| start_req | input | 1 | Level: this controller has issued a start |
| start_det | input | 1 | Strobe: start or repeated start seen on the bus |
| stop_det | input | 1 | Strobe: stop condition seen |
| err_stop_det | input | 1 | Strobe: stop seen in an illegal position |
| scl_rise | input | 1 | Strobe: SCL rising edge |
| scl_fall | input | 1 | Strobe: SCL falling edge |
| bit_idx | input | IDX_W | Index (1..9) of the SCL clock within the byte, valid with the edge strobes |
| arb_lost | input | 1 | Strobe: arbitration lost |
| addr_match | input | 1 | Strobe: primary or secondary own address matched |
| gcall_det | input | 1 | Strobe: general call address received |
| rw_bit | input | 1 | Direction bit of the received address, valid with gcall_det |
| ack_rx | input | 1 | Strobe: acknowledge bit received |
| ack_val | input | 1 | Value of the received acknowledge bit (1 = not acknowledged) |
| clr_we | input | 1 | CPU write strobe to the flag |
| clr_wdata | input | 1 | CPU write data for the flag |
| irq | output | 1 | Registered interrupt request flag |

## Verification
Every result of this block appears exactly one clock edge after the event that causes it. The reason is that only one register lies between any strobe and irq. The window and the arbitration-loss/first-frame trackers add state, but no extra delay. The bench drives each strobe for one cycle on a falling clock edge. It removes the strobe and samples irq at the next falling edge, after exactly one rising edge. Before each table vector the bench returns the state to a known point: a masked stop closes the window and clears the arbitration-loss latch, and a CPU clear empties the flag.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

  typedef struct packed {
    logic mstart;
    logic mbyte;
    logic alframe;
    logic alirq;
    logic nack;
    logic smatch;
    logic sbyte;
    logic stop;
  } irq_src_t;

  localparam int NUM_SRC = $bits(irq_src_t);

endpackage

// File: rtl/irqf_byte_timing.sv
module irqf_byte_timing #(
  parameter int BYTE_BITS = 8,
  parameter int IDX_W     = 4
) (
  input  logic             wait_en,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic [IDX_W-1:0] bit_idx,
  output logic             byte_end,
  output logic             ninth_rise
);
  localparam logic [IDX_W-1:0] WAIT_IDX = IDX_W'(BYTE_BITS);
  localparam logic [IDX_W-1:0] ACK_IDX  = IDX_W'(BYTE_BITS + 1);

  logic last_data_fall;

  always_comb begin
    last_data_fall = scl_fall && (bit_idx == WAIT_IDX);
    ninth_rise     = scl_rise && (bit_idx == ACK_IDX);
    byte_end       = wait_en ? last_data_fall : ninth_rise;
  end
endmodule

// File: rtl/irqf_master_track.sv
module irqf_master_track (
  input  logic clk,
  input  logic rst,
  input  logic start_det,
  input  logic stop_any,
  input  logic arb_lost,
  input  logic ninth_rise,
  output logic al_frame_hit
);
  logic first_frame_q;
  logic al_lat_q;

  // first frame after a start runs until its 9th clock rises
  always_ff @(posedge clk) begin
    if (rst) begin
      first_frame_q <= 1'b0;
    end else if (start_det) begin
      first_frame_q <= 1'b1;
    end else if (ninth_rise) begin
      first_frame_q <= 1'b0;
    end
  end

  // arbitration loss is remembered until the next start or stop
  always_ff @(posedge clk) begin
    if (rst) begin
      al_lat_q <= 1'b0;
    end else if (arb_lost) begin
      al_lat_q <= 1'b1;
    end else if (start_det || stop_any) begin
      al_lat_q <= 1'b0;
    end
  end

  always_comb begin
    al_frame_hit = al_lat_q && first_frame_q && ninth_rise;
  end
endmodule

// File: rtl/irqf_slave_window.sv
module irqf_slave_window (
  input  logic clk,
  input  logic rst,
  input  logic open_req,
  input  logic close_req,
  output logic window_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      window_q <= 1'b0;
    end else if (close_req) begin
      window_q <= 1'b0;
    end else if (open_req) begin
      window_q <= 1'b1;
    end
  end
endmodule

// File: rtl/irqf_flag_reg.sv
module irqf_flag_reg #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src,
  input  logic               clr_we,
  input  logic               clr_wdata,
  output logic               set_any,
  output logic               flag_q
);
  logic clr_hit;

  always_comb begin
    set_any = |src;
    clr_hit = clr_we && !clr_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (set_any) begin
      flag_q <= 1'b1;
    end else if (clr_hit) begin
      flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_irq_flag_gen.sv
module i2c_irq_flag_gen
  import irqf_pkg::*;
#(
  parameter  int BYTE_BITS = 8,
  localparam int IDX_W     = $clog2(BYTE_BITS + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_master,
  input  logic             wait_en,
  input  logic             ack_chk_en,
  input  logic             al_irq_en,
  input  logic             stop_irq_mask,
  input  logic             start_req,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             err_stop_det,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             arb_lost,
  input  logic             addr_match,
  input  logic             gcall_det,
  input  logic             rw_bit,
  input  logic             ack_rx,
  input  logic             ack_val,
  input  logic             clr_we,
  input  logic             clr_wdata,
  output logic             irq
);
  logic     byte_end;
  logic     ninth_rise;
  logic     al_frame_hit;
  logic     window_q;
  logic     stop_any;
  logic     gcall_wr;
  logic     open_req;
  logic     set_any;
  logic     flag_q;
  irq_src_t src;

  always_comb begin
    stop_any = stop_det || err_stop_det;
    gcall_wr = gcall_det && !rw_bit;
    open_req = addr_match || gcall_wr;
  end

  irqf_byte_timing #(
    .BYTE_BITS (BYTE_BITS),
    .IDX_W     (IDX_W)
  ) u_timing (
    .wait_en    (wait_en),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .bit_idx    (bit_idx),
    .byte_end   (byte_end),
    .ninth_rise (ninth_rise)
  );

  irqf_master_track u_mtrack (
    .clk          (clk),
    .rst          (rst),
    .start_det    (start_det),
    .stop_any     (stop_any),
    .arb_lost     (arb_lost),
    .ninth_rise   (ninth_rise),
    .al_frame_hit (al_frame_hit)
  );

  irqf_slave_window u_window (
    .clk       (clk),
    .rst       (rst),
    .open_req  (open_req),
    .close_req (start_det || stop_any),
    .window_q  (window_q)
  );

  always_comb begin
    src.mstart  = mode_master && start_det && start_req;
    src.mbyte   = mode_master && byte_end;
    src.alframe = mode_master && al_frame_hit;
    src.alirq   = al_irq_en && arb_lost;
    src.nack    = ack_chk_en && ack_rx && ack_val;
    src.smatch  = !mode_master && open_req;
    src.sbyte   = !mode_master && window_q && byte_end;
    src.stop    = !stop_irq_mask && stop_any;
  end

  irqf_flag_reg #(
    .NUM_SRC (NUM_SRC)
  ) u_flag (
    .clk       (clk),
    .rst       (rst),
    .src       (src),
    .clr_we    (clr_we),
    .clr_wdata (clr_wdata),
    .set_any   (set_any),
    .flag_q    (flag_q)
  );

  assign irq = flag_q;
endmodule

// File: rtl/irqf_checker.sv
module irqf_checker #(
  parameter int BYTE_BITS = 8,
  parameter int IDX_W     = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_master,
  input logic             wait_en,
  input logic             ack_chk_en,
  input logic             al_irq_en,
  input logic             stop_irq_mask,
  input logic             start_req,
  input logic             start_det,
  input logic             stop_det,
  input logic             err_stop_det,
  input logic             scl_fall,
  input logic [IDX_W-1:0] bit_idx,
  input logic             arb_lost,
  input logic             ack_rx,
  input logic             ack_val,
  input logic             clr_we,
  input logic             clr_wdata,
  input logic             set_any,
  input logic             irq
);
  localparam logic [IDX_W-1:0] WAIT_IDX = IDX_W'(BYTE_BITS);

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> !irq); // R1

  AST_MASTER_START: assert property (@(posedge clk) disable iff (rst)
    (mode_master && start_det && start_req) |=> irq); // R2

  AST_WAIT_FALL: assert property (@(posedge clk) disable iff (rst)
    (mode_master && wait_en && scl_fall && bit_idx == WAIT_IDX) |=> irq); // R3

  AST_AL_IRQ: assert property (@(posedge clk) disable iff (rst)
    (arb_lost && al_irq_en) |=> irq); // R6

  AST_NACK: assert property (@(posedge clk) disable iff (rst)
    (ack_chk_en && ack_rx && ack_val) |=> irq); // R7

  AST_STOP_SET: assert property (@(posedge clk) disable iff (rst)
    ((stop_det || err_stop_det) && !stop_irq_mask) |=> irq); // R11

  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq && !(clr_we && !clr_wdata)) |=> irq); // R12

  AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !clr_wdata && !set_any) |=> !irq); // R12

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (!irq && !set_any) |=> !irq); // R12
endmodule

bind i2c_irq_flag_gen irqf_checker #(
  .BYTE_BITS (BYTE_BITS),
  .IDX_W     (IDX_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mode_master   (mode_master),
  .wait_en       (wait_en),
  .ack_chk_en    (ack_chk_en),
  .al_irq_en     (al_irq_en),
  .stop_irq_mask (stop_irq_mask),
  .start_req     (start_req),
  .start_det     (start_det),
  .stop_det      (stop_det),
  .err_stop_det  (err_stop_det),
  .scl_fall      (scl_fall),
  .bit_idx       (bit_idx),
  .arb_lost      (arb_lost),
  .ack_rx        (ack_rx),
  .ack_val       (ack_val),
  .clr_we        (clr_we),
  .clr_wdata     (clr_wdata),
  .set_any       (set_any),
  .irq           (irq)
);

// File: tb/i2c_irq_flag_gen_bench.sv
`timescale 1ns/1ps
module i2c_irq_flag_gen_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       mode_master, wait_en, ack_chk_en, al_irq_en, stop_irq_mask;
  logic       start_req, start_det, stop_det, err_stop_det;
  logic       scl_rise, scl_fall;
  logic [3:0] bit_idx;
  logic       arb_lost, addr_match, gcall_det, rw_bit, ack_rx, ack_val;
  logic       clr_we, clr_wdata;
  logic       irq;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  i2c_irq_flag_gen u_i2c_irq_flag_gen (
    .clk(clk), .rst(rst), .mode_master(mode_master), .wait_en(wait_en),
    .ack_chk_en(ack_chk_en), .al_irq_en(al_irq_en), .stop_irq_mask(stop_irq_mask),
    .start_req(start_req), .start_det(start_det), .stop_det(stop_det),
    .err_stop_det(err_stop_det), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bit_idx(bit_idx), .arb_lost(arb_lost), .addr_match(addr_match),
    .gcall_det(gcall_det), .rw_bit(rw_bit), .ack_rx(ack_rx), .ack_val(ack_val),
    .clr_we(clr_we), .clr_wdata(clr_wdata), .irq(irq)
  );

  typedef struct packed {
    logic       mode;
    logic       wt;
    logic       ackc;
    logic       alie;
    logic       smask;
    logic       sreq;
    logic       start;
    logic       rise;
    logic       fall;
    logic [3:0] idx;
    logic       al;
    logic       ack;
    logic       ackv;
    logic       stop;
    logic       estop;
    logic       exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    // mode wt ackc alie smask sreq start rise fall idx al ack ackv stop estop exp
    '{1,0,0,0,1,1,1,0,0,4'd0,0,0,0,0,0,1}, // R2 own start seen
    '{1,0,0,0,1,0,1,0,0,4'd0,0,0,0,0,0,0}, // R13 foreign start, master
    '{0,0,0,0,1,1,1,0,0,4'd0,0,0,0,0,0,0}, // R13 start in slave mode
    '{1,1,0,0,1,0,0,0,1,4'd8,0,0,0,0,0,1}, // R3 wait: 8th fall
    '{1,1,0,0,1,0,0,1,0,4'd9,0,0,0,0,0,0}, // R3 wait: 9th rise ignored
    '{1,0,0,0,1,0,0,1,0,4'd9,0,0,0,0,0,1}, // R4 no wait: 9th rise
    '{1,0,0,0,1,0,0,0,1,4'd8,0,0,0,0,0,0}, // R4 no wait: 8th fall ignored
    '{1,0,0,0,1,0,0,1,0,4'd8,0,0,0,0,0,0}, // R4 8th rise ignored
    '{1,1,0,1,1,0,0,0,0,4'd0,1,0,0,0,0,1}, // R6 arb lost enabled
    '{1,1,0,0,1,0,0,0,0,4'd0,1,0,0,0,0,0}, // R6 arb lost disabled
    '{0,0,1,0,1,0,0,0,0,4'd0,0,1,1,0,0,1}, // R7 nack in slave
    '{1,0,0,0,1,0,0,0,0,4'd0,0,1,1,0,0,0}, // R7 nack, check disabled
    '{1,0,1,0,1,0,0,0,0,4'd0,0,1,0,0,0,0}, // R7 ack 0
    '{0,0,0,0,0,0,0,0,0,4'd0,0,0,0,1,0,1}, // R11 stop unmasked
    '{1,0,0,0,0,0,0,0,0,4'd0,0,0,0,0,1,1}, // R11 error stop unmasked
    '{0,0,0,0,1,0,0,0,0,4'd0,0,0,0,1,0,0}, // R11 stop masked
    '{0,0,0,0,1,0,0,1,0,4'd9,0,0,0,0,0,0}  // R10 slave byte end, window closed
  };

  task automatic idle_strobes();
    start_det = 0; stop_det = 0; err_stop_det = 0; scl_rise = 0; scl_fall = 0;
    bit_idx = 0; arb_lost = 0; addr_match = 0; gcall_det = 0; rw_bit = 0;
    ack_rx = 0; ack_val = 0; clr_we = 0; clr_wdata = 0;
  endtask

  // one rising edge, then back on a falling edge with strobes removed
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle_strobes();
  endtask

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s: irq=%b expected %b", tag, irq, exp);
    end
  endtask

  task automatic cpu_clear();
    clr_we = 1; clr_wdata = 0; step();
  endtask

  // masked stop: closes window, drops the arbitration-loss latch; then clear
  task automatic scrub();
    stop_irq_mask = 1; stop_det = 1; step();
    cpu_clear();
  endtask

  task automatic edge_at(input logic rise, input logic [3:0] idx);
    scl_rise = rise; scl_fall = !rise; bit_idx = idx; step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: irq=%b expected end of run", irq);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst = 1; mode_master = 0; wait_en = 0; ack_chk_en = 0; al_irq_en = 0;
    stop_irq_mask = 1; start_req = 0;
    idle_strobes();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(1'b0, "R1 reset value");
    rst = 0;
    step();
    chk(1'b0, "R1 after reset release");

    for (int i = 0; i < NV; i++) begin
      scrub();
      mode_master = VECS[i].mode; wait_en = VECS[i].wt; ack_chk_en = VECS[i].ackc;
      al_irq_en = VECS[i].alie; stop_irq_mask = VECS[i].smask; start_req = VECS[i].sreq;
      start_det = VECS[i].start; scl_rise = VECS[i].rise; scl_fall = VECS[i].fall;
      bit_idx = VECS[i].idx; arb_lost = VECS[i].al; ack_rx = VECS[i].ack;
      ack_val = VECS[i].ackv; stop_det = VECS[i].stop; err_stop_det = VECS[i].estop;
      step();
      chk(VECS[i].exp, $sformatf("vector %0d", i));
      start_req = 0; ack_chk_en = 0; al_irq_en = 0;
    end

    // R5: first frame after arbitration loss, wait enabled
    scrub(); mode_master = 1; wait_en = 1; stop_irq_mask = 1;
    start_det = 1; step();
    arb_lost = 1; step();
    chk(1'b0, "R6 arb lost alone, disabled");
    edge_at(1'b1, 4'd9);
    chk(1'b1, "R5 first frame after arb lost");
    cpu_clear();
    edge_at(1'b1, 4'd9);
    chk(1'b0, "R5 second frame does not set");
    scrub(); mode_master = 1; wait_en = 1;
    start_det = 1; step();
    edge_at(1'b1, 4'd9);
    chk(1'b0, "R5 first frame without arb lost");

    // R8 / R10: own-address window
    scrub(); mode_master = 0; wait_en = 0;
    edge_at(1'b1, 4'd9);
    chk(1'b0, "R10 closed window before match");
    addr_match = 1; step();
    chk(1'b1, "R8 address match");
    cpu_clear();
    edge_at(1'b1, 4'd9);
    chk(1'b1, "R8 byte end in window, no wait");
    cpu_clear();
    wait_en = 1;
    edge_at(1'b0, 4'd8);
    chk(1'b1, "R8 byte end in window, wait");
    cpu_clear();
    start_det = 1; step();
    chk(1'b0, "R13 repeated start, slave");
    edge_at(1'b0, 4'd8);
    chk(1'b0, "R10 window closed by start");

    // R9 / R10: general call window
    scrub(); mode_master = 0; wait_en = 0;
    gcall_det = 1; rw_bit = 1; step();
    chk(1'b0, "R9 general call with read");
    edge_at(1'b1, 4'd9);
    chk(1'b0, "R9 read call opens no window");
    gcall_det = 1; rw_bit = 0; step();
    chk(1'b1, "R9 general call with write");
    cpu_clear();
    edge_at(1'b1, 4'd9);
    chk(1'b1, "R9 byte end after general call");
    cpu_clear();
    stop_irq_mask = 1; err_stop_det = 1; step();
    chk(1'b0, "R11 masked error stop");
    edge_at(1'b1, 4'd9);
    chk(1'b0, "R10 window closed by stop");

    // R12: sticky behaviour and set priority
    scrub(); mode_master = 1; stop_irq_mask = 0;
    stop_det = 1; step();
    chk(1'b1, "R12 set");
    repeat (3) step();
    chk(1'b1, "R12 holds");
    clr_we = 1; clr_wdata = 1; step();
    chk(1'b1, "R12 write 1 no effect");
    cpu_clear();
    chk(1'b0, "R12 write 0 clears");
    stop_det = 1; clr_we = 1; clr_wdata = 0; step();
    chk(1'b1, "R12 set wins over clear");

    // R1: reset while set
    rst = 1; step();
    chk(1'b0, "R1 reset clears set flag");
    rst = 0; step();
    chk(1'b0, "R1 stays clear after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule